// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block serves an MMU miss handler. It takes one request at a time: a 64-bit virtual address, the access types the access needs (read, write, execute) and an access mode (kernel, user or physical). It returns a physical address, the set of access types it grants, and either a success flag or a fault code. Addresses in physical mode pass through unchanged. Addresses outside the implemented sign-extended range fail. A kernel-only direct-mapped window in the negative half of the address space is translated without any memory access. All other addresses are resolved by walking a three-level table held in memory, through a 64-bit read port that uses a request/valid handshake.

Pages are 8 KB, so the page offset is 13 bits wide. 43 virtual address bits are implemented. Each table level is indexed by a 10-bit slice of the virtual page number. Each entry of a table is 64 bits wide. The upper 32 bits of an entry give the page frame number of the next table, or of the data page at the last level. The low bits of an entry carry a valid flag, per-mode read and write enables, and three fault-on flags. Each fault-on flag removes one access type from the granted set.

Top module: `ptw_walker`

## Requirements
- R1: When `req_mode[1]` is 1 (physical mode), the response comes in the cycle after acceptance with no memory read. It has `resp_ok`=1, `resp_fault`=0, `resp_paddr` equal to the request address and `resp_perm`=3'b111.
- R2: In kernel (`req_mode`=0) or user (`req_mode`=1) mode, an address whose bits [63:43] are not all equal fails with the access-violation code 0, without any memory read.
- R3: A kernel-mode address with bit 63 set and bits [42:41]=2'b10 is a window hit, served with no memory read. It gives `resp_ok`=1, `resp_perm`=3'b111 and a physical address made of bits [39:0] of the request, with request bit 40 placed at bit 43 and all other bits zero. A negative address with bits [42:41]=2'b11 is walked instead.
- R4: A window-hit address in user mode fails with access violation (code 0), without any memory read.
- R5: The walk reads exactly three entries, one per level, each as a one-cycle `mem_req` pulse. The entry address is the table base plus 8 times the level index. The indices are bits [42:33], [32:23] and [22:13] in that order. The first base is `ptbr`, and each later base is entry bits [63:32] shifted left by 13. The walker moves on only after `mem_rvalid`.
- R6: If the valid bit (entry bit 0) is clear at any level, the walk stops at that level with the translation-not-valid code 4.
- R7: At the first and second level, an entry that is valid but has its kernel read-enable (bit 8) clear stops the walk with access violation (code 0).
- R8: At the last level, read and execute are granted by bit 8 in kernel mode or bit 9 in user mode, and write by bit 12 or bit 13. `req_need` and `resp_perm` use bit 0 for read, bit 1 for write and bit 2 for execute. A non-zero need with none of its types granted fails with access violation (code 0).
- R9: Last-level bits 1, 2 and 3 withdraw read, write and execute from the granted set. If a needed type then remains in neither set, the fault is code 3 when execute is needed. Otherwise it is code 2 when write is needed, and otherwise code 1.
- R10: A successful walk returns `resp_ok`=1 and `resp_fault`=0. The physical address is the last entry's bits [63:32] shifted left by 13, with the request's page offset in the low 13 bits, and the permissions are the masked granted set. Any failure returns `resp_ok`=0 with `resp_perm`=0 and `resp_paddr`=0.
- R11: A request is accepted only while `req_ready` is high, which is only when no walk is pending. Requests presented while busy are dropped. `resp_valid` is a single-cycle pulse, and `req_ready` is high again in the next cycle.
- R12: After reset, `req_ready` is high, `resp_valid` is low and `mem_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 64 | Virtual address |
| req_need | input | 3 | Needed access types: bit 0 read, bit 1 write, bit 2 execute |
| req_mode | input | 2 | 0 kernel, 1 user, 2 or 3 physical |
| ptbr | input | 64 | Base address of the first-level table |
| mem_req | output | 1 | One-cycle read request pulse |
| mem_addr | output | 64 | Address of the table entry to read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Table entry read |
| resp_valid | output | 1 | Result pulse |
| resp_ok | output | 1 | Translation succeeded |
| resp_fault | output | 3 | 0 access violation, 1/2/3 fault-on read/write/execute, 4 not valid |
| resp_perm | output | 3 | Granted access types |
| resp_paddr | output | 64 | Physical address |

## Verification
The assertions assume a memory that answers each `mem_req` with exactly one `mem_rvalid` pulse. That pulse comes no earlier than the cycle after the request, and never while no read is pending. They also assume `ptbr` stays stable while a request is being accepted. The bench's memory model keeps within this. It sees each request pulse on a falling edge and answers one to three cycles later, rotating the latency. It lowers the valid line before it looks for the next pulse. Walk scenarios use page tables built from index-derived frame numbers, and all expected results come from those tables.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int unsigned ADDR_W = 64;
  localparam int unsigned PTE_W  = 64;
  localparam int unsigned PFN_LO = 32;
  localparam int unsigned PFN_W  = PTE_W - PFN_LO;
  localparam int unsigned NLVL   = 3;

  // entry flag positions (behavioural: decoded by the walk)
  localparam int unsigned B_VALID = 0;
  localparam int unsigned B_FO_LO = 1;   // fault-on read/write/exec at 1..3
  localparam int unsigned B_RDEN  = 8;   // kernel read enable, user at +1
  localparam int unsigned B_WREN  = 12;  // kernel write enable, user at +1

  // access type positions in need/perm vectors
  localparam int unsigned A_RD = 0;
  localparam int unsigned A_WR = 1;
  localparam int unsigned A_EX = 2;

  typedef enum logic [2:0] {
    FLT_ACV = 3'd0,
    FLT_FOR = 3'd1,
    FLT_FOW = 3'd2,
    FLT_FOE = 3'd3,
    FLT_TNV = 3'd4
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1, ST_L2, ST_L3, ST_DONE
  } walk_st_e;

  typedef enum logic [2:0] {
    VC_PHYS, VC_BADSIGN, VC_WINDOW, VC_WINDOW_DENY, VC_WALK
  } vclass_e;

  typedef struct packed {
    logic              ok;
    fault_e            fault;
    logic [2:0]        perm;
    logic [ADDR_W-1:0] paddr;
  } result_t;

  function automatic result_t mk_ok(input logic [ADDR_W-1:0] pa, input logic [2:0] pm);
    result_t r;
    r.ok    = 1'b1;
    r.fault = FLT_ACV;
    r.perm  = pm;
    r.paddr = pa;
    return r;
  endfunction

  function automatic result_t mk_fail(input fault_e f);
    result_t r;
    r.ok    = 1'b0;
    r.fault = f;
    r.perm  = '0;
    r.paddr = '0;
    return r;
  endfunction

endpackage

// File: rtl/ptw_rst_sync.sv
module ptw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_int_n = sync_q[STAGES-1];
endmodule

// File: rtl/ptw_vclass.sv
module ptw_vclass
  import ptw_pkg::*;
#(
  parameter int unsigned IMPL_BITS = 43,
  parameter int unsigned WIN_LO    = 40
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [1:0]        mode,
  output vclass_e           cls,
  output logic [ADDR_W-1:0] win_paddr
);
  localparam int unsigned TOP_N   = ADDR_W - IMPL_BITS + 1;  // bits IMPL_BITS-1 .. 63 incl. sign copy check
  localparam int unsigned SEL_HI  = IMPL_BITS - 1;
  localparam int unsigned DST_BIT = WIN_LO + 3;

  logic [ADDR_W-IMPL_BITS-1:0] upper;
  logic sign_ok, win_hit;

  assign upper   = vaddr[ADDR_W-1:IMPL_BITS];
  assign sign_ok = (&upper) | ~(|upper);
  assign win_hit = vaddr[ADDR_W-1] & (vaddr[SEL_HI -: 2] == 2'b10);

  always_comb begin
    win_paddr          = '0;
    win_paddr[WIN_LO-1:0] = vaddr[WIN_LO-1:0];
    win_paddr[DST_BIT] = vaddr[WIN_LO];
  end

  always_comb begin
    if (mode[1])          cls = VC_PHYS;
    else if (!sign_ok)    cls = VC_BADSIGN;
    else if (win_hit)     cls = (mode == 2'd0) ? VC_WINDOW : VC_WINDOW_DENY;
    else                  cls = VC_WALK;
  end

  localparam int unsigned UNUSED_TOP = TOP_N;
endmodule

// File: rtl/ptw_idx.sv
module ptw_idx
  import ptw_pkg::*;
#(
  parameter int unsigned IDX_W = 10
) (
  input  logic [IDX_W*NLVL-1:0] vpn,
  input  logic [1:0]            lvl,
  input  logic [ADDR_W-1:0]     base,
  output logic [ADDR_W-1:0]     entry_addr
);
  localparam int unsigned ENT_SH = 3;

  logic [IDX_W-1:0] idx_arr [NLVL];
  logic [IDX_W-1:0] sel;

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    assign idx_arr[g] = vpn[IDX_W*(NLVL-1-g) +: IDX_W];
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (lvl == 2'(i)) sel = idx_arr[i];
    end
  end

  assign entry_addr = base + (ADDR_W'(sel) << ENT_SH);
endmodule

// File: rtl/ptw_perm.sv
module ptw_perm
  import ptw_pkg::*;
(
  input  logic       user,
  input  logic [2:0] need,
  input  logic [1:0] rd_en,    // {user, kernel}
  input  logic [1:0] wr_en,    // {user, kernel}
  input  logic [2:0] fo_bits,  // {exec, write, read}
  output logic       ok,
  output fault_e     fault,
  output logic [2:0] perm
);
  logic       rd, wr;
  logic [2:0] grant, masked;

  assign rd = rd_en[user];
  assign wr = wr_en[user];

  always_comb begin
    grant       = '0;
    grant[A_RD] = rd;
    grant[A_EX] = rd;
    grant[A_WR] = wr;
  end

  assign masked = grant & ~fo_bits;

  always_comb begin
    ok    = 1'b0;
    fault = FLT_ACV;
    perm  = '0;
    if ((need != 3'b000) && ((grant & need) == 3'b000)) begin
      fault = FLT_ACV;
    end else if ((need != 3'b000) && ((masked & need) == 3'b000)) begin
      if (need[A_EX])      fault = FLT_FOE;
      else if (need[A_WR]) fault = FLT_FOW;
      else                 fault = FLT_FOR;
    end else begin
      ok   = 1'b1;
      perm = masked;
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned IMPL_BITS = 43,
  parameter int unsigned PB        = 13,
  parameter int unsigned IDX_W     = 10,
  parameter int unsigned WIN_LO    = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [2:0]        req_need,
  input  logic [1:0]        req_mode,
  input  logic [ADDR_W-1:0] ptbr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [PTE_W-1:0]  mem_rdata,
  output logic              resp_valid,
  output logic              resp_ok,
  output logic [2:0]        resp_fault,
  output logic [2:0]        resp_perm,
  output logic [ADDR_W-1:0] resp_paddr
);
  localparam int unsigned VPN_W = IDX_W * NLVL;
  localparam int unsigned KEEP_W = PB + VPN_W;

  logic rst_int_n;

  walk_st_e            state_q, state_n;
  logic                wait_q, wait_n;
  logic [KEEP_W-1:0]   vaddr_q;
  logic [2:0]          need_q;
  logic                user_q;
  logic [ADDR_W-1:0]   base_q, base_n;
  result_t             res_q, res_n;
  logic                cap_en, base_en, res_en;

  vclass_e             cls;
  logic [ADDR_W-1:0]   win_paddr;
  logic [1:0]          lvl;
  logic [ADDR_W-1:0]   pte_page;
  logic                p_ok;
  fault_e              p_fault;
  logic [2:0]          p_perm;
  logic                in_walk;

  ptw_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  ptw_vclass #(.IMPL_BITS(IMPL_BITS), .WIN_LO(WIN_LO)) u_vclass (
    .vaddr     (req_vaddr),
    .mode      (req_mode),
    .cls       (cls),
    .win_paddr (win_paddr)
  );

  always_comb begin
    unique case (state_q)
      ST_L2:   lvl = 2'd1;
      ST_L3:   lvl = 2'd2;
      default: lvl = 2'd0;
    endcase
  end

  ptw_idx #(.IDX_W(IDX_W)) u_idx (
    .vpn        (vaddr_q[KEEP_W-1:PB]),
    .lvl        (lvl),
    .base       (base_q),
    .entry_addr (mem_addr)
  );

  ptw_perm u_perm (
    .user    (user_q),
    .need    (need_q),
    .rd_en   (mem_rdata[B_RDEN +: 2]),
    .wr_en   (mem_rdata[B_WREN +: 2]),
    .fo_bits (mem_rdata[B_FO_LO +: 3]),
    .ok      (p_ok),
    .fault   (p_fault),
    .perm    (p_perm)
  );

  assign pte_page = ADDR_W'({mem_rdata[PTE_W-1:PFN_LO], {PB{1'b0}}});
  assign in_walk  = (state_q == ST_L1) || (state_q == ST_L2) || (state_q == ST_L3);

  // next state
  always_comb begin
    state_n = state_q;
    wait_n  = wait_q;
    base_n  = base_q;
    res_n   = res_q;
    cap_en  = 1'b0;
    base_en = 1'b0;
    res_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          cap_en  = 1'b1;
          res_en  = 1'b1;
          state_n = ST_DONE;
          unique case (cls)
            VC_PHYS:   res_n = mk_ok(req_vaddr, 3'b111);
            VC_WINDOW: res_n = mk_ok(win_paddr, 3'b111);
            VC_WALK: begin
              res_en  = 1'b0;
              state_n = ST_L1;
              base_n  = ptbr;
              base_en = 1'b1;
              wait_n  = 1'b0;
            end
            default:   res_n = mk_fail(FLT_ACV);
          endcase
        end
      end
      ST_L1, ST_L2, ST_L3: begin
        if (!wait_q) begin
          wait_n = 1'b1;
        end else if (mem_rvalid) begin
          wait_n = 1'b0;
          if (!mem_rdata[B_VALID]) begin
            res_en  = 1'b1;
            res_n   = mk_fail(FLT_TNV);
            state_n = ST_DONE;
          end else if (state_q != ST_L3) begin
            if (!mem_rdata[B_RDEN]) begin
              res_en  = 1'b1;
              res_n   = mk_fail(FLT_ACV);
              state_n = ST_DONE;
            end else begin
              base_en = 1'b1;
              base_n  = pte_page;
              state_n = (state_q == ST_L1) ? ST_L2 : ST_L3;
            end
          end else begin
            res_en  = 1'b1;
            state_n = ST_DONE;
            res_n   = p_ok ? mk_ok(pte_page | ADDR_W'(vaddr_q[PB-1:0]), p_perm)
                           : mk_fail(p_fault);
          end
        end
      end
      ST_DONE: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
    if (!rst_int_n) begin
      cap_en  = 1'b0;
      base_en = 1'b0;
      res_en  = 1'b0;
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= 1'b0;
    end else if (!rst_int_n) begin
      state_q <= ST_IDLE;
      wait_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      wait_q  <= wait_n;
    end
  end

  // data registers with explicit enables
  always_ff @(posedge clk) begin
    if (cap_en) begin
      vaddr_q <= req_vaddr[KEEP_W-1:0];
      need_q  <= req_need;
      user_q  <= req_mode[0];
    end
    if (base_en) base_q <= base_n;
    if (res_en)  res_q  <= res_n;
  end

  assign req_ready  = (state_q == ST_IDLE) && rst_int_n;
  assign mem_req    = in_walk && !wait_q;
  assign resp_valid = (state_q == ST_DONE);
  assign resp_ok    = res_q.ok;
  assign resp_fault = res_q.fault;
  assign resp_perm  = res_q.perm;
  assign resp_paddr = res_q.paddr;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
  import ptw_pkg::*;
#(
  parameter int unsigned IMPL_BITS = 43,
  parameter int unsigned WIN_SEL   = 41
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic [2:0]        req_need,
  input logic [1:0]        req_mode,
  input logic              mem_req,
  input logic              mem_rvalid,
  input logic              resp_valid,
  input logic              resp_ok,
  input logic [2:0]        resp_fault,
  input logic [2:0]        resp_perm,
  input logic [ADDR_W-1:0] resp_paddr
);
  logic accept, sign_good, win;

  assign accept    = req_valid && req_ready;
  assign sign_good = (&req_vaddr[ADDR_W-1:IMPL_BITS]) || !(|req_vaddr[ADDR_W-1:IMPL_BITS]);
  assign win       = req_vaddr[ADDR_W-1] && (req_vaddr[WIN_SEL+1:WIN_SEL] == 2'b10);

  AST_PHYS_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_mode[1]) |=> (resp_valid && resp_ok && resp_perm == 3'b111 &&
                                 resp_paddr == $past(req_vaddr)));                 // R1
  AST_SIGN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_mode[1] && !sign_good) |=> (resp_valid && !resp_ok && resp_fault == 3'd0)); // R2
  AST_WINDOW_USER: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_mode == 2'd1 && sign_good && win) |=> (resp_valid && !resp_ok && resp_fault == 3'd0)); // R4
  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);                                                          // R5
  AST_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);                                                        // R11
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> (!resp_valid && req_ready));                                     // R11
  AST_FAIL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ok) |-> (resp_perm == 3'b000 && resp_paddr == '0 && resp_fault <= 3'd4)); // R10
  AST_OK_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_ok) |-> (resp_fault == 3'd0));                              // R10

  logic unused_in;
  assign unused_in = ^{req_need, mem_rvalid};
endmodule

bind ptw_walker ptw_walker_chk #(.IMPL_BITS(IMPL_BITS)) u_chk (.*);

// File: tb/test_ptw_walker.sv
`timescale 1ns/1ps
module test_ptw_walker;

  localparam int PB = 13;
  localparam logic [63:0] PTBR = 64'h0000_0000_0001_0000;
  localparam logic [31:0] F_V   = 32'h0001;
  localparam logic [31:0] F_FOR = 32'h0002;
  localparam logic [31:0] F_FOW = 32'h0004;
  localparam logic [31:0] F_FOE = 32'h0008;
  localparam logic [31:0] F_KRE = 32'h0100;
  localparam logic [31:0] F_URE = 32'h0200;
  localparam logic [31:0] F_KWE = 32'h1000;
  localparam logic [31:0] F_UWE = 32'h2000;

  logic        clk, rst_n;
  logic        req_valid, req_ready;
  logic [63:0] req_vaddr;
  logic [2:0]  req_need;
  logic [1:0]  req_mode;
  logic [63:0] ptbr;
  logic        mem_req, mem_rvalid;
  logic [63:0] mem_addr, mem_rdata;
  logic        resp_valid, resp_ok;
  logic [2:0]  resp_fault, resp_perm;
  logic [63:0] resp_paddr;

  ptw_walker i_ptw_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_need(req_need), .req_mode(req_mode), .ptbr(ptbr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .resp_valid(resp_valid), .resp_ok(resp_ok), .resp_fault(resp_fault),
    .resp_perm(resp_perm), .resp_paddr(resp_paddr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic        ok;
    logic [2:0]  fault;
    logic [2:0]  perm;
    logic [63:0] paddr;
    int          reads;
    string       tag;
  } exp_t;

  exp_t        sbq[$];
  logic [63:0] pmem [logic [63:0]];
  int          n_chk = 0;
  int          n_fail = 0;
  int          rd_cnt = 0;
  int          lat_sel = 0;

  task automatic check(input bit cond, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_va(input int i1, input int i2, input int i3, input int off);
    return {21'b0, i1[9:0], i2[9:0], i3[9:0], off[12:0]};
  endfunction

  function automatic logic [63:0] mk_pte(input logic [31:0] pfn, input logic [31:0] low);
    return {pfn, low};
  endfunction

  function automatic logic [63:0] page(input logic [31:0] pfn);
    return {19'b0, pfn, 13'b0};
  endfunction

  task automatic map3(input int i1, input int i2, input int i3,
                      input logic [31:0] l1low, input logic [31:0] l2low, input logic [63:0] l3);
    logic [31:0] p2, p3;
    p2 = 32'h100 + 32'(i1);
    p3 = 32'h200 + 32'(i1);
    pmem[PTBR + 64'(i1) * 8]     = mk_pte(p2, l1low);
    pmem[page(p2) + 64'(i2) * 8] = mk_pte(p3, l2low);
    pmem[page(p3) + 64'(i3) * 8] = l3;
  endtask

  // memory responder: one rvalid per request, 1..3 cycles later
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (rst_n && mem_req) begin
        logic [63:0] a;
        a = mem_addr;
        rd_cnt++;
        repeat (1 + lat_sel) @(negedge clk);
        mem_rdata  = pmem.exists(a) ? pmem[a] : 64'h0;
        mem_rvalid = 1'b1;
        lat_sel    = (lat_sel + 1) % 3;
      end
    end
  end

  // monitor: pop and compare
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R11", "unexpected response", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(resp_ok == e.ok, e.tag, "ok", 64'(resp_ok), 64'(e.ok));
        check(resp_fault == e.fault, e.tag, "fault", 64'(resp_fault), 64'(e.fault));
        check(resp_perm == e.perm, e.tag, "perm", 64'(resp_perm), 64'(e.perm));
        check(resp_paddr == e.paddr, e.tag, "paddr", resp_paddr, e.paddr);
        check(rd_cnt == e.reads, e.tag, "reads", 64'(rd_cnt), 64'(e.reads));
      end
      rd_cnt = 0;
    end
  end

  task automatic go(input logic [63:0] va, input logic [2:0] need, input logic [1:0] mode,
                    input logic ok, input logic [2:0] flt, input logic [2:0] pm,
                    input logic [63:0] pa, input int reads, input string tag, input bit poke);
    exp_t e;
    e.ok = ok; e.fault = ok ? 3'd0 : flt; e.perm = ok ? pm : 3'd0;
    e.paddr = ok ? pa : 64'd0; e.reads = reads; e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_need = need; req_mode = mode;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      // R11: a request while busy must be dropped
      check(req_ready == 1'b0, "R11", "ready while walking", 64'(req_ready), 64'd0);
      req_valid = 1'b1; req_vaddr = 64'h1234; req_mode = 2'd2;
      @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (!(req_ready && sbq.size() == 0)) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_need = '0; req_mode = '0;
    ptbr = PTBR;

    map3(1, 5, 9, F_V|F_KRE, F_V|F_KRE, mk_pte(32'h7001, F_V|F_KRE|F_KWE));
    map3(2, 3, 4, F_V|F_KRE, F_V|F_KRE, mk_pte(32'h7002, F_V|F_URE|F_UWE));
    map3(3, 3, 4, F_V|F_KRE, F_V|F_KRE, mk_pte(32'h7003, F_V|F_KRE|F_KWE));
    map3(4, 3, 4, F_V|F_KRE, F_V|F_KRE, mk_pte(32'h7004, F_V|F_URE));
    map3(6, 1, 1, F_V|F_KRE, F_V,       mk_pte(32'h7006, F_V|F_KRE));
    map3(7, 1, 1, F_V,       F_V|F_KRE, mk_pte(32'h7007, F_V|F_KRE));
    map3(8, 2, 2, F_V|F_KRE, F_V|F_KRE, mk_pte(32'h7008, F_KRE));
    map3(9, 2, 2, F_V|F_KRE, F_KRE,     mk_pte(32'h7009, F_V|F_KRE));
    map3(10, 7, 8, F_V|F_KRE, F_V|F_KRE, mk_pte(32'h700A, F_V|F_KRE|F_KWE|F_FOE));
    map3(11, 7, 8, F_V|F_KRE, F_V|F_KRE, mk_pte(32'h700B, F_V|F_KRE|F_KWE|F_FOR|F_FOW));
    map3(12, 7, 8, F_V|F_KRE, F_V|F_KRE, mk_pte(32'h700C, F_V|F_KRE|F_KWE|F_FOR|F_FOW|F_FOE));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    check(req_ready == 1'b1, "R12", "req_ready", 64'(req_ready), 64'd1);
    check(resp_valid == 1'b0, "R12", "resp_valid", 64'(resp_valid), 64'd0);
    check(mem_req == 1'b0, "R12", "mem_req", 64'(mem_req), 64'd0);

    // R1 physical bypass
    go(64'hDEAD_BEEF_0123_4567, 3'b001, 2'd2, 1, 0, 3'b111, 64'hDEAD_BEEF_0123_4567, 0, "R1", 0);
    go(64'hFFFF_0000_0000_0042, 3'b010, 2'd3, 1, 0, 3'b111, 64'hFFFF_0000_0000_0042, 0, "R1", 0);
    // R2 sign extension
    go(64'h0000_0800_0000_0000, 3'b001, 2'd0, 0, 0, 0, 0, 0, "R2", 0);
    go(64'hFFFF_F000_0000_0000, 3'b001, 2'd1, 0, 0, 0, 0, 0, "R2", 0);
    // R3 kernel window, with and without bit 40
    go(64'hFFFF_FD12_3456_789A, 3'b001, 2'd0, 1, 0, 3'b111, 64'h0000_0812_3456_789A, 0, "R3", 0);
    go(64'hFFFF_FC00_0000_1000, 3'b100, 2'd0, 1, 0, 3'b111, 64'h0000_0000_0000_1000, 0, "R3", 0);
    // R3 bits [42:41]=11 is walked: first index 0x300 unmapped
    go(64'hFFFF_FE00_0000_0000, 3'b001, 2'd0, 0, 3'd4, 0, 0, 1, "R3", 0);
    // R4 user window
    go(64'hFFFF_FD12_3456_789A, 3'b001, 2'd1, 0, 0, 0, 0, 0, "R4", 0);
    // R5 R10 full walks, with a busy poke (R11)
    go(mk_va(1, 5, 9, 'h123), 3'b001, 2'd0, 1, 0, 3'b111, page(32'h7001) | 64'h123, 3, "R5", 1);
    go(mk_va(1, 5, 9, 'h1FFF), 3'b010, 2'd0, 1, 0, 3'b111, page(32'h7001) | 64'h1FFF, 3, "R10", 0);
    // R8 per-mode enables
    go(mk_va(2, 3, 4, 'h10), 3'b010, 2'd1, 1, 0, 3'b111, page(32'h7002) | 64'h10, 3, "R8", 0);
    go(mk_va(3, 3, 4, 'h10), 3'b001, 2'd1, 0, 3'd0, 0, 0, 3, "R8", 0);
    go(mk_va(4, 3, 4, 'h10), 3'b010, 2'd1, 0, 3'd0, 0, 0, 3, "R8", 0);
    go(mk_va(4, 3, 4, 'h20), 3'b100, 2'd1, 1, 0, 3'b101, page(32'h7004) | 64'h20, 3, "R8", 0);
    // R6 not-valid at each level
    go(mk_va(5, 1, 1, 0), 3'b001, 2'd0, 0, 3'd4, 0, 0, 1, "R6", 0);
    go(mk_va(9, 2, 2, 0), 3'b001, 2'd0, 0, 3'd4, 0, 0, 2, "R6", 0);
    go(mk_va(8, 2, 2, 0), 3'b001, 2'd0, 0, 3'd4, 0, 0, 3, "R6", 0);
    // R7 missing read enable at upper levels
    go(mk_va(7, 1, 1, 0), 3'b001, 2'd0, 0, 3'd0, 0, 0, 1, "R7", 0);
    go(mk_va(6, 1, 1, 0), 3'b001, 2'd0, 0, 3'd0, 0, 0, 2, "R7", 0);
    // R9 fault-on bits and priority
    go(mk_va(10, 7, 8, 4), 3'b100, 2'd0, 0, 3'd3, 0, 0, 3, "R9", 0);
    go(mk_va(10, 7, 8, 4), 3'b001, 2'd0, 1, 0, 3'b011, page(32'h700A) | 64'h4, 3, "R9", 0);
    go(mk_va(11, 7, 8, 4), 3'b011, 2'd0, 0, 3'd2, 0, 0, 3, "R9", 0);
    go(mk_va(11, 7, 8, 4), 3'b001, 2'd0, 0, 3'd1, 0, 0, 3, "R9", 0);
    go(mk_va(11, 7, 8, 4), 3'b111, 2'd0, 1, 0, 3'b100, page(32'h700B) | 64'h4, 3, "R9", 0);
    go(mk_va(12, 7, 8, 4), 3'b111, 2'd0, 0, 3'd3, 0, 0, 3, "R9", 0);
    go(mk_va(12, 7, 8, 4), 3'b000, 2'd0, 1, 0, 3'b000, page(32'h700C) | 64'h4, 3, "R10", 0);

    repeat (5) @(negedge clk);
    check(sbq.size() == 0, "R11", "pending expectations", 64'(sbq.size()), 64'd0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule